// File: doc/BRIEF.md
# PC Card Byte-Lane Steering Decoder

This block is the glue between a 16-bit removable-card host bus and an array of byte-wide memory devices arranged as even/odd pairs. It examines the two active-low card enables, address bit 0, the three upper address bits that choose a device pair, the output and write enables, the space-select input and a write-protect switch. From these it produces one active-low chip select per device and a chip select for a separate attribute memory. It also produces the enables and direction of the two data-lane transceivers, a control that moves the odd byte onto the low lane, and the write strobe to the devices.

The card enables pick the access width. With only the low enable asserted, the access is byte-wide on the low lane. With only the high enable asserted, only the odd byte is accessed, on the high lane. With both asserted, the access is a 16-bit word. With neither asserted, the card is in standby. When the space-select input is low, the access goes to the attribute memory. In that space only even bytes on the low lane carry valid data, so every odd-byte path stays blank there. All decoded outputs are registered and appear one clock after the inputs are sampled. The card-detect and battery-detect status outputs are constants.

Top module: `pcs_lane_steer`

## Requirements
- R1: Byte mode is low enable asserted and high enable deasserted, with the space-select input high. In this mode, exactly one device is selected: device 2p when A0=0 and device 2p+1 when A0=1, where p is the pair address. Device i is bit i of the device-select bus, and a select is active when it is 0.
- R2: In byte mode with A0=1 and an active read or write, the low lane is enabled, the high lane is disabled and the lane-swap output is 1.
- R3: When only the high enable is asserted, device 2p+1 alone is selected. Only the high lane is enabled, the lane swap is 0, and A0 has no effect.
- R4: When both enables are asserted, devices 2p and 2p+1 are both selected, both lanes are enabled for an active access, and the lane swap is 0.
- R5: When both enables are deasserted, all device and attribute selects are 1, both lanes are disabled, the direction output is 0 and the device write strobe is 1.
- R6: When OE and WE are both high, the lanes are disabled and the direction output is 0. During a read (OE low, WE high), the direction output is 1, meaning the card drives the host.
- R7: With the space-select input low and the card enabled, the attribute select is 0 and all device selects are 1. The low lane is enabled only for byte mode with A0=0 or for word mode. The high lane and the lane swap stay 0.
- R8: With the write-protect switch at 1, the device write strobe stays 1 and the write-protect status output is 1.
- R9: A cycle with OE and WE both low is illegal. It issues no write strobe and enables no lane.
- R10: The two card-detect outputs are constant 0 and the two battery-detect outputs are constant 1.
- R11: While reset is low, all selects and the write strobe are 1 and the lane and status outputs are 0. Every decoded output changes on the clock edge after its inputs change, and not before.
- R12: The attribute select and any device select are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_lo_n | input | 1 | Low-lane card enable, active low |
| ce_hi_n | input | 1 | High-lane card enable, active low |
| a0 | input | 1 | Byte address bit (even/odd) |
| pair_adr | input | 3 | Device pair address |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| space_n | input | 1 | Low selects attribute space |
| wp_sw | input | 1 | Write-protect switch, 1 = protected |
| dev_cs_n | output | 16 | Per-device chip selects, active low |
| attr_cs_n | output | 1 | Attribute memory chip select, active low |
| dev_we_n | output | 1 | Write strobe to devices, active low |
| lo_lane_en | output | 1 | Low-lane transceiver enable |
| hi_lane_en | output | 1 | High-lane transceiver enable |
| to_host | output | 1 | Transceiver direction, 1 = card drives host |
| odd_swap | output | 1 | Route odd byte onto low lane |
| wp_stat | output | 1 | Write-protect status |
| cd_n | output | 2 | Card-detect status |
| bvd | output | 2 | Battery-detect status |

## Verification
The bench targets the points where a decoder commonly fails. One is a byte access with A0 high: a design that forgets the swap puts the odd byte on the high lane and leaves the host reading a floating low lane. Another is odd-only mode with A0 toggled: a decoder that still looks at A0 selects the even device. In attribute space, odd-byte accesses must blank both lanes, or invalid data is driven. The bench also covers the illegal OE-and-WE-low case and the write-protect case, where a stray write strobe would corrupt a device. Finally, it checks the one-cycle latency, because an unregistered path would show outputs before the clock edge.

// File: rtl/pcs_pkg.sv
// Shared types for the byte-lane steering decoder.
package pcs_pkg;
    // Access width chosen by the two card enables.
    typedef enum logic [1:0] {
        MD_IDLE = 2'd0,
        MD_BYTE = 2'd1,
        MD_ODD  = 2'd2,
        MD_WORD = 2'd3
    } pcs_mode_e;
endpackage

// File: rtl/pcs_mode_decode.sv
// Classifies the access from the card enables and the strobe pair.
// Assumes all inputs are already synchronous to the block clock.
module pcs_mode_decode
    import pcs_pkg::*;
(
    input  logic      ce_lo_n,
    input  logic      ce_hi_n,
    input  logic      oe_n,
    input  logic      we_n,
    output pcs_mode_e mode,
    output logic      rd,
    output logic      wr,
    output logic      illegal
);
    // Width selection from the enable pair.
    always_comb begin
        unique case ({ce_hi_n, ce_lo_n})
            2'b10:   mode = MD_BYTE;
            2'b01:   mode = MD_ODD;
            2'b00:   mode = MD_WORD;
            default: mode = MD_IDLE;
        endcase
    end

    // Strobe classification; both low is rejected.
    always_comb begin
        rd      = !oe_n && we_n;
        wr      = oe_n && !we_n;
        illegal = !oe_n && !we_n;
    end
endmodule

// File: rtl/pcs_select_decode.sv
// Produces active-high device and attribute selects for one access.
// Assumes the pair address is in range of NPAIR.
module pcs_select_decode
    import pcs_pkg::*;
#(
    parameter int NPAIR  = 8,
    localparam int PW    = $clog2(NPAIR),
    localparam int NDEV  = 2 * NPAIR
) (
    input  pcs_mode_e         mode,
    input  logic              a0,
    input  logic [PW-1:0]     pair_adr,
    input  logic              space_n,
    output logic [NDEV-1:0]   dev_sel,
    output logic              attr_sel
);
    logic array_acc;
    logic want_even;
    logic want_odd;

    // Which half of the addressed pair the mode requests.
    always_comb begin
        array_acc = (mode != MD_IDLE) && space_n;
        want_even = (mode == MD_WORD) || ((mode == MD_BYTE) && !a0);
        want_odd  = (mode == MD_WORD) || (mode == MD_ODD) || ((mode == MD_BYTE) && a0);
        attr_sel  = (mode != MD_IDLE) && !space_n;
    end

    // One even/odd select pair per device pair.
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        logic hit;
        assign hit            = array_acc && (pair_adr == PW'(p));
        assign dev_sel[2*p]   = hit && want_even;
        assign dev_sel[2*p+1] = hit && want_odd;
    end
endmodule

// File: rtl/pcs_lane_ctrl.sv
// Drives the transceiver enables, direction and odd-to-low swap.
// Assumes the mode and strobe classification from pcs_mode_decode.
module pcs_lane_ctrl
    import pcs_pkg::*;
(
    input  pcs_mode_e mode,
    input  logic      a0,
    input  logic      space_n,
    input  logic      rd,
    input  logic      wr,
    output logic      lo_en,
    output logic      hi_en,
    output logic      swap,
    output logic      to_host
);
    logic active;

    // Lane steering; attribute space carries only the even low byte.
    always_comb begin
        active  = (mode != MD_IDLE) && (rd || wr);
        to_host = active && rd;
        if (space_n) begin
            lo_en = active && ((mode == MD_BYTE) || (mode == MD_WORD));
            hi_en = active && ((mode == MD_ODD) || (mode == MD_WORD));
            swap  = active && (mode == MD_BYTE) && a0;
        end else begin
            lo_en = active && (((mode == MD_BYTE) && !a0) || (mode == MD_WORD));
            hi_en = 1'b0;
            swap  = 1'b0;
        end
    end
endmodule

// File: rtl/pcs_lane_steer.sv
// Top of the byte-lane steering decoder: decodes the host access and
// registers every control output once per clock.
// Assumes host signals are synchronised to clk upstream.
module pcs_lane_steer
    import pcs_pkg::*;
#(
    parameter int NPAIR  = 8,
    localparam int PW    = $clog2(NPAIR),
    localparam int NDEV  = 2 * NPAIR
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ce_lo_n,
    input  logic            ce_hi_n,
    input  logic            a0,
    input  logic [PW-1:0]   pair_adr,
    input  logic            oe_n,
    input  logic            we_n,
    input  logic            space_n,
    input  logic            wp_sw,
    output logic [NDEV-1:0] dev_cs_n,
    output logic            attr_cs_n,
    output logic            dev_we_n,
    output logic            lo_lane_en,
    output logic            hi_lane_en,
    output logic            to_host,
    output logic            odd_swap,
    output logic            wp_stat,
    output logic [1:0]      cd_n,
    output logic [1:0]      bvd
);
    pcs_mode_e       mode;
    logic            rd, wr, illegal;
    logic [NDEV-1:0] dev_sel;
    logic            attr_sel;
    logic            lo_nx, hi_nx, swap_nx, dir_nx, strobe_nx;

    pcs_mode_decode u_mode (
        .ce_lo_n (ce_lo_n),
        .ce_hi_n (ce_hi_n),
        .oe_n    (oe_n),
        .we_n    (we_n),
        .mode    (mode),
        .rd      (rd),
        .wr      (wr),
        .illegal (illegal)
    );

    pcs_select_decode #(.NPAIR(NPAIR)) u_sel (
        .mode     (mode),
        .a0       (a0),
        .pair_adr (pair_adr),
        .space_n  (space_n),
        .dev_sel  (dev_sel),
        .attr_sel (attr_sel)
    );

    pcs_lane_ctrl u_lane (
        .mode    (mode),
        .a0      (a0),
        .space_n (space_n),
        .rd      (rd),
        .wr      (wr),
        .lo_en   (lo_nx),
        .hi_en   (hi_nx),
        .swap    (swap_nx),
        .to_host (dir_nx)
    );

    // Write strobe gated by the switch and by the illegal strobe pair.
    always_comb strobe_nx = (mode != MD_IDLE) && wr && !illegal && !wp_sw;

    // Output register stage with synchronous reset to the inactive state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_cs_n   <= '1;
            attr_cs_n  <= 1'b1;
            dev_we_n   <= 1'b1;
            lo_lane_en <= 1'b0;
            hi_lane_en <= 1'b0;
            to_host    <= 1'b0;
            odd_swap   <= 1'b0;
            wp_stat    <= 1'b0;
        end else begin
            dev_cs_n   <= ~dev_sel;
            attr_cs_n  <= ~attr_sel;
            dev_we_n   <= ~strobe_nx;
            lo_lane_en <= lo_nx;
            hi_lane_en <= hi_nx;
            to_host    <= dir_nx;
            odd_swap   <= swap_nx;
            wp_stat    <= wp_sw;
        end
    end

    // Card status pins: always seated, no battery.
    assign cd_n = 2'b00;
    assign bvd  = 2'b11;
endmodule

// File: rtl/pcs_lane_steer_chk.sv
// Property checker for pcs_lane_steer, attached by bind below.
module pcs_lane_steer_chk #(
    parameter int NDEV = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ce_lo_n,
    input logic            ce_hi_n,
    input logic            a0,
    input logic            oe_n,
    input logic            we_n,
    input logic            space_n,
    input logic            wp_sw,
    input logic [NDEV-1:0] dev_cs_n,
    input logic            attr_cs_n,
    input logic            dev_we_n,
    input logic            lo_lane_en,
    input logic            hi_lane_en,
    input logic            odd_swap,
    input logic            wp_stat
);
    AST_BYTE_ONE_DEV: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !ce_lo_n && ce_hi_n && space_n) |-> ($countones(~dev_cs_n) == 1)); // R1
    AST_SWAP_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        odd_swap |-> (lo_lane_en && !hi_lane_en)); // R2
    AST_ODD_NO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && ce_lo_n && !ce_hi_n) |-> !lo_lane_en); // R3
    AST_WORD_TWO_DEV: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !ce_lo_n && !ce_hi_n && space_n) |-> ($countones(~dev_cs_n) == 2)); // R4
    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && ce_lo_n && ce_hi_n) |-> (&dev_cs_n && attr_cs_n && dev_we_n && !lo_lane_en && !hi_lane_en)); // R5
    AST_ATTR_HI_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !attr_cs_n |-> (!hi_lane_en && !odd_swap)); // R7
    AST_WP_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && wp_sw) |-> (dev_we_n && wp_stat)); // R8
    AST_ILLEGAL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !oe_n && !we_n) |-> (dev_we_n && !lo_lane_en && !hi_lane_en)); // R9
    AST_SEL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !attr_cs_n |-> (&dev_cs_n)); // R12
endmodule

bind pcs_lane_steer pcs_lane_steer_chk #(.NDEV(NDEV)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_lo_n    (ce_lo_n),
    .ce_hi_n    (ce_hi_n),
    .a0         (a0),
    .oe_n       (oe_n),
    .we_n       (we_n),
    .space_n    (space_n),
    .wp_sw      (wp_sw),
    .dev_cs_n   (dev_cs_n),
    .attr_cs_n  (attr_cs_n),
    .dev_we_n   (dev_we_n),
    .lo_lane_en (lo_lane_en),
    .hi_lane_en (hi_lane_en),
    .odd_swap   (odd_swap),
    .wp_stat    (wp_stat)
);

// File: tb/test_pcs_lane_steer.sv
module test_pcs_lane_steer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ce_lo_n, ce_hi_n, a0, oe_n, we_n, space_n, wp_sw;
    logic [2:0]  pair_adr;
    logic [15:0] dev_cs_n;
    logic        attr_cs_n, dev_we_n, lo_lane_en, hi_lane_en, to_host, odd_swap, wp_stat;
    logic [1:0]  cd_n, bvd;
    int          errors = 0;
    int          checks = 0;

    always #10 clk = ~clk;

    pcs_lane_steer i_pcs_lane_steer (
        .clk(clk), .rst_n(rst_n), .ce_lo_n(ce_lo_n), .ce_hi_n(ce_hi_n),
        .a0(a0), .pair_adr(pair_adr), .oe_n(oe_n), .we_n(we_n),
        .space_n(space_n), .wp_sw(wp_sw), .dev_cs_n(dev_cs_n),
        .attr_cs_n(attr_cs_n), .dev_we_n(dev_we_n), .lo_lane_en(lo_lane_en),
        .hi_lane_en(hi_lane_en), .to_host(to_host), .odd_swap(odd_swap),
        .wp_stat(wp_stat), .cd_n(cd_n), .bvd(bvd)
    );

    // Stimulus {ce_lo_n,ce_hi_n,a0,pair[2:0],oe_n,we_n,space_n,wp_sw},
    // expected selects, tail {attr_cs_n,dev_we_n,lo,hi,to_host,swap,wp_stat}, req.
    localparam logic [36:0] VEC [16] = '{
        {10'b0_1_0_000_0_1_1_0, 16'hFFFE, 7'b1_1_1_0_1_0_0, 4'd1},  // R1 even byte read
        {10'b0_1_1_011_0_1_1_0, 16'hFF7F, 7'b1_1_1_0_1_1_0, 4'd2},  // R2 odd byte swapped
        {10'b1_0_0_101_0_1_1_0, 16'hF7FF, 7'b1_1_0_1_1_0_0, 4'd3},  // R3 odd only, a0=0
        {10'b1_0_1_101_0_1_1_0, 16'hF7FF, 7'b1_1_0_1_1_0_0, 4'd3},  // R3 odd only, a0=1
        {10'b0_0_0_111_0_1_1_0, 16'h3FFF, 7'b1_1_1_1_1_0_0, 4'd4},  // R4 word read
        {10'b0_0_1_010_1_0_1_0, 16'hFFCF, 7'b1_0_1_1_0_0_0, 4'd4},  // R4 word write
        {10'b1_1_0_000_0_1_1_0, 16'hFFFF, 7'b1_1_0_0_0_0_0, 4'd5},  // R5 standby
        {10'b0_1_0_001_1_1_1_0, 16'hFFFB, 7'b1_1_0_0_0_0_0, 4'd6},  // R6 output disable
        {10'b0_1_0_100_0_1_0_0, 16'hFFFF, 7'b0_1_1_0_1_0_0, 4'd7},  // R7 attr even
        {10'b0_1_1_100_0_1_0_0, 16'hFFFF, 7'b0_1_0_0_1_0_0, 4'd7},  // R7 attr odd blank
        {10'b0_0_0_100_0_1_0_0, 16'hFFFF, 7'b0_1_1_0_1_0_0, 4'd7},  // R7 attr word
        {10'b1_0_0_100_0_1_0_0, 16'hFFFF, 7'b0_1_0_0_1_0_0, 4'd7},  // R7 attr odd-only
        {10'b0_1_0_110_1_0_1_1, 16'hEFFF, 7'b1_1_1_0_0_0_1, 4'd8},  // R8 protected write
        {10'b0_1_0_000_0_0_1_0, 16'hFFFE, 7'b1_1_0_0_0_0_0, 4'd9},  // R9 illegal strobes
        {10'b0_1_1_000_1_0_1_0, 16'hFFFD, 7'b1_0_1_0_0_1_0, 4'd1},  // R1 odd byte write
        {10'b0_1_0_000_1_0_0_0, 16'hFFFF, 7'b0_0_1_0_0_0_0, 4'd7}   // R7 attr write
    };

    task automatic drive(input logic [9:0] s);
        {ce_lo_n, ce_hi_n, a0, pair_adr, oe_n, we_n, space_n, wp_sw} = s;
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [22:0] outs();
        return {dev_cs_n, attr_cs_n, dev_we_n, lo_lane_en, hi_lane_en, to_host, odd_swap, wp_stat};
    endfunction

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive(10'b0_0_1_000_1_0_1_1);
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11", 32'(outs()), 32'({16'hFFFF, 7'b1_1_0_0_0_0_0}));
        // R10 constant status pins
        check("R10", 32'({cd_n, bvd}), 32'(4'b0011));
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            drive(VEC[i][36:27]);
            @(negedge clk);
            check($sformatf("R%0d vec%0d", VEC[i][3:0], i), 32'(outs()), 32'(VEC[i][26:4]));
        end
        // R11 latency: new inputs do not reach outputs before the edge
        @(negedge clk);
        drive(10'b0_0_0_111_0_1_1_0);
        @(negedge clk);
        drive(10'b1_1_0_000_0_1_1_0);
        #1 check("R11 hold", 32'(outs()), 32'({16'h3FFF, 7'b1_1_1_1_1_0_0}));
        @(negedge clk);
        check("R11 update", 32'(outs()), 32'({16'hFFFF, 7'b1_1_0_0_0_0_0}));
        // R3 a0 toggled on odd-only keeps same select, R12 exclusivity in attr space
        drive(10'b1_0_1_010_0_1_1_0);
        @(negedge clk);
        check("R3 a0", 32'(dev_cs_n), 32'(16'hFFDF));
        drive(10'b0_0_1_010_0_1_0_0);
        @(negedge clk);
        check("R12", 32'({attr_cs_n, dev_cs_n}), 32'({1'b0, 16'hFFFF}));
        check("R10 run", 32'({cd_n, bvd}), 32'(4'b0011));
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule